// File: doc/BRIEF.md
# Configurable Integer Min/Max Unit

A purely combinational datapath slice that picks the smaller or larger of two XLEN-bit integer operands. A 3-bit mode field chooses three things. It sets whether the compare uses the full width or only the low half (word compare). It sets whether the ordering is signed or unsigned. It sets whether the unit returns the minimum or the maximum. The returned value is always one of the two original operands in full, even when only the low halves were compared.

All orderings share one unsigned full-width comparator. For a word compare, each compare key is the operand's low half moved into the upper half, with the lower half zero-filled. For a signed compare, the key's top bit is inverted. When the record flag is set, a 4-bit condition field built from the compare is published with a write enable. The field's lowest bit is the incoming sticky-overflow bit. The first operand can be forced to zero, which a decoder uses when that operand's register field is zero.

Top module: `minmax_sel_unit`

## Requirements
- R1: When `opa_zero_i` is 1, operand A is taken as zero for both the compare and the result. Otherwise operand A is `opa_i`. Operand B is always `opb_i`.
- R2: Mode encoding is `mode_i[2]` = word compare, `mode_i[1]` = signed compare and `mode_i[0]` = maximum. With all three bits at 0, the result is the unsigned minimum of the two full-width operands.
- R3: With `mode_i[1]` = 1, the ordering is two's-complement signed, over the full width or over the low half in word mode.
- R4: With `mode_i[2]` = 1, only the low XLEN/2 bits of each operand decide the ordering. Upper-half differences have no effect on the choice.
- R5: The result is always the whole original operand A (after R1) or the whole operand B, never truncated, even in word mode.
- R6: `cond_o[3:1]` is 100 when key A is below key B, 010 when it is above and 001 when the keys are equal. The compare is taken before any min/max swap, and `cond_o[0]` equals `so_i`.
- R7: `cond_we_o` equals `rec_i`. With `rec_i` at 0, no condition write is requested.
- R8: When the two compare keys are equal, the result is operand B in both min and max modes.
- R9: With `mode_i[0]` = 1, the result is the operand with the greater key under the selected ordering.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| opa_i | input | XLEN | First operand value |
| opb_i | input | XLEN | Second operand value |
| opa_zero_i | input | 1 | Force operand A to zero |
| mode_i | input | 3 | {word, signed, max} selection |
| rec_i | input | 1 | Request a condition-field write |
| so_i | input | 1 | Sticky-overflow bit copied into the field |
| res_o | output | XLEN | Selected operand |
| cond_o | output | 4 | {less, greater, equal, sticky-overflow} |
| cond_we_o | output | 1 | Condition-field write enable |

## Verification
The block has no registers, so `res_o`, `cond_o` and `cond_we_o` are all due in the same cycle the inputs change, after combinational settling only. The bench applies every stimulus on the falling clock edge and samples one nanosecond later, well before the next edge. No check therefore depends on edge ordering or on any latency. Every one of the eight mode combinations is run against a reference model built from the requirements. The operand pairs include equal keys, sign-boundary values and pairs whose upper halves differ.

// File: rtl/mmu_pkg.sv
// Package: shared mode type for the min/max unit.
// Assumes the 3-bit mode field arrives as {word, signed, max}.
package mmu_pkg;
    typedef struct packed {
        logic word;
        logic sgn;
        logic max;
    } mm_mode_t;
endpackage

// File: rtl/mm_key_former.sv
// Module: builds an unsigned compare key from one operand.
// A word compare moves the low half into the top half and zero-fills the rest.
// A signed compare inverts the key's top bit, so unsigned order gives signed order.
// Assumes XLEN is even.
module mm_key_former #(
    parameter int XLEN = 64
) (
    input  logic [XLEN-1:0] op_i,
    input  logic            word_i,
    input  logic            sgn_i,
    output logic [XLEN-1:0] key_o
);
    localparam int HALF = XLEN / 2;

    // Purpose: shift for a word compare, then flip the sign bit for a signed compare.
    always_comb begin
        key_o = word_i ? {op_i[HALF-1:0], {HALF{1'b0}}} : op_i;
        if (sgn_i) key_o[XLEN-1] = ~key_o[XLEN-1];
    end

    // Purpose: in word mode, no lower-half bit of the key may take part in the compare.
    always_comb begin
        if (!$isunknown(word_i) && word_i && !$isunknown(key_o))
            AST_WORD_LOW_CLEAR: assert (key_o[HALF-1:0] == '0); // R4
    end
endmodule

// File: rtl/mm_ucompare.sv
// Module: unsigned full-width comparator with three exclusive relation outputs.
// Assumes the keys have already been prepared for the selected ordering.
module mm_ucompare #(
    parameter int XLEN = 64
) (
    input  logic [XLEN-1:0] ka_i,
    input  logic [XLEN-1:0] kb_i,
    output logic            lt_o,
    output logic            gt_o,
    output logic            eq_o
);
    // Purpose: derive less, greater and equal from a single magnitude compare.
    always_comb begin
        lt_o = ka_i < kb_i;
        eq_o = ka_i == kb_i;
        gt_o = !lt_o && !eq_o;
    end

    // Purpose: exactly one relation must hold for any pair of known keys.
    always_comb begin
        if (!$isunknown({ka_i, kb_i}))
            AST_ONE_RELATION: assert ($onehot({lt_o, gt_o, eq_o})); // R6
    end
endmodule

// File: rtl/mm_pick.sv
// Module: picks the whole operand A or B from the compare outcome.
// Max mode swaps the roles of the keys. On a tie, operand B is returned.
// Assumes the lt/gt/eq inputs describe key A against key B.
module mm_pick #(
    parameter int XLEN = 64
) (
    input  logic [XLEN-1:0] opa_i,
    input  logic [XLEN-1:0] opb_i,
    input  logic            lt_i,
    input  logic            gt_i,
    input  logic            eq_i,
    input  logic            max_i,
    output logic [XLEN-1:0] res_o
);
    logic take_a;

    // Purpose: the final less-than test, with the operands swapped in max mode.
    always_comb begin
        take_a = max_i ? gt_i : lt_i;
        res_o  = take_a ? opa_i : opb_i;
    end

    // Purpose: the result is always a whole operand, and a tie always yields B.
    always_comb begin
        if (!$isunknown({opa_i, opb_i, lt_i, gt_i, eq_i, max_i})) begin
            AST_WHOLE_OPERAND: assert (res_o == opa_i || res_o == opb_i); // R5
            if (eq_i)
                AST_TIE_TO_B: assert (res_o == opb_i); // R8
        end
    end
endmodule

// File: rtl/minmax_sel_unit.sv
// Module: top of the configurable integer min/max unit.
// Purely combinational; register access and pipelining belong to the caller.
// Assumes mode_i = {word, signed, max} and that XLEN is even.
module minmax_sel_unit
    import mmu_pkg::*;
#(
    parameter int XLEN = 64
) (
    input  logic [XLEN-1:0] opa_i,
    input  logic [XLEN-1:0] opb_i,
    input  logic            opa_zero_i,
    input  logic [2:0]      mode_i,
    input  logic            rec_i,
    input  logic            so_i,
    output logic [XLEN-1:0] res_o,
    output logic [3:0]      cond_o,
    output logic            cond_we_o
);
    localparam int NOPS = 2;

    mm_mode_t        mode;
    logic [XLEN-1:0] opa_eff;
    logic [XLEN-1:0] ops  [NOPS];
    logic [XLEN-1:0] keys [NOPS];
    logic            lt, gt, eq;

    // Purpose: decode the mode field and apply the zero substitution to operand A.
    always_comb begin
        mode    = mm_mode_t'(mode_i);
        opa_eff = opa_zero_i ? '0 : opa_i;
        ops[0]  = opa_eff;
        ops[1]  = opb_i;
    end

    // One identical key former per operand.
    for (genvar g = 0; g < NOPS; g++) begin : g_key
        mm_key_former #(.XLEN(XLEN)) u_key (
            .op_i   (ops[g]),
            .word_i (mode.word),
            .sgn_i  (mode.sgn),
            .key_o  (keys[g])
        );
    end

    mm_ucompare #(.XLEN(XLEN)) u_cmp (
        .ka_i (keys[0]),
        .kb_i (keys[1]),
        .lt_o (lt),
        .gt_o (gt),
        .eq_o (eq)
    );

    mm_pick #(.XLEN(XLEN)) u_pick (
        .opa_i (opa_eff),
        .opb_i (opb_i),
        .lt_i  (lt),
        .gt_i  (gt),
        .eq_i  (eq),
        .max_i (mode.max),
        .res_o (res_o)
    );

    // Purpose: build the condition field from the unswapped compare and gate its write.
    always_comb begin
        cond_o    = {lt, gt, eq, so_i};
        cond_we_o = rec_i;
    end

    // Purpose: with A forced to zero, the result is either zero or operand B.
    always_comb begin
        if (!$isunknown({opa_zero_i, res_o, opb_i}) && opa_zero_i)
            AST_ZERO_SUB: assert (res_o == '0 || res_o == opb_i); // R1
        if (!$isunknown({rec_i, cond_we_o}))
            AST_WE_FOLLOWS_REC: assert (cond_we_o == rec_i); // R7
        if (!$isunknown({so_i, cond_o}))
            AST_SO_APPENDED: assert (cond_o[0] == so_i); // R6
    end
endmodule

// File: tb/minmax_sel_unit_test.sv
module minmax_sel_unit_test;
    localparam int XLEN = 64;
    localparam int HALF = XLEN / 2;

    typedef struct packed {
        logic [XLEN-1:0] a;
        logic [XLEN-1:0] b;
        logic            z;
        logic [2:0]      mode;
        logic [XLEN-1:0] exp;
    } vec_t;

    // Hand-worked vectors: {a, b, zero, mode{word,signed,max}, expected result}
    localparam vec_t VECS [8] = '{
        '{64'd5, 64'd9, 1'b0, 3'b000, 64'd5},                                  // R2 unsigned min
        '{64'd5, 64'd9, 1'b0, 3'b001, 64'd9},                                  // R9 unsigned max
        '{64'hFFFF_FFFF_FFFF_FFFF, 64'd1, 1'b0, 3'b010, 64'hFFFF_FFFF_FFFF_FFFF}, // R3 signed min
        '{64'hFFFF_FFFF_FFFF_FFFF, 64'd1, 1'b0, 3'b000, 64'd1},                // R2 unsigned min
        '{64'h0000_0001_0000_0002, 64'd3, 1'b0, 3'b100, 64'h0000_0001_0000_0002}, // R5 whole operand
        '{64'h1234_5678_0000_0007, 64'd7, 1'b0, 3'b100, 64'd7},                // R4/R8 tie on low half
        '{64'h0000_0000_8000_0000, 64'd1, 1'b0, 3'b110, 64'h0000_0000_8000_0000}, // R3 word signed min
        '{64'hFFFF_FFFF_FFFF_FFFF, 64'd3, 1'b1, 3'b000, 64'd0}                 // R1 zero substitution
    };

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [XLEN-1:0] opa = '0, opb = '0;
    logic            opa_zero = 1'b0, rec = 1'b0, so = 1'b0;
    logic [2:0]      mode = '0;
    logic [XLEN-1:0] res;
    logic [3:0]      cond;
    logic            cond_we;
    int              checks = 0, failures = 0;

    always #2.5 clk = ~clk;

    minmax_sel_unit #(.XLEN(XLEN)) uut (
        .opa_i(opa), .opb_i(opb), .opa_zero_i(opa_zero), .mode_i(mode),
        .rec_i(rec), .so_i(so), .res_o(res), .cond_o(cond), .cond_we_o(cond_we)
    );

    // Reference key built from the requirement text.
    function automatic logic [XLEN-1:0] ref_key(input logic [XLEN-1:0] v, input logic w, input logic s);
        logic [XLEN-1:0] k;
        k = w ? (v << HALF) : v;
        if (s) k = k ^ (64'd1 << (XLEN-1));
        return k;
    endfunction

    task automatic check(input string req, input logic [XLEN-1:0] act, input logic [XLEN-1:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic apply(input logic [XLEN-1:0] a, input logic [XLEN-1:0] b, input logic z,
                         input logic [2:0] m, input logic r, input logic s);
        @(negedge clk);
        opa = a; opb = b; opa_zero = z; mode = m; rec = r; so = s;
        #1;
    endtask

    // Compare against the reference model for one operand pair in every mode.
    task automatic sweep(input logic [XLEN-1:0] a, input logic [XLEN-1:0] b, input logic z);
        for (int m = 0; m < 8; m++) begin
            logic [XLEN-1:0] ea, ka, kb, er;
            logic [3:0]      ec;
            logic            mx;
            ea = z ? '0 : a;
            ka = ref_key(ea, m[2], m[1]);
            kb = ref_key(b, m[2], m[1]);
            mx = m[0];
            if (ka == kb)     er = b;
            else if (mx)      er = (ka > kb) ? ea : b;
            else              er = (ka < kb) ? ea : b;
            ec = (ka < kb) ? 4'b1001 : (ka > kb) ? 4'b0101 : 4'b0011;
            apply(a, b, z, 3'(m), 1'b1, 1'b1);
            check("R2/R3/R4/R9 sweep result", res, er);
            check("R6 sweep cond", {60'd0, cond}, {60'd0, ec});
        end
    endtask

    initial begin : watchdog
        #200000;
        failures++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        // Reset / idle state: zero operands, record off
        #1;
        check("R7 idle we", {63'd0, cond_we}, 64'd0);
        check("R8 idle res", res, 64'd0);

        // Table walk
        for (int i = 0; i < 8; i++) begin
            apply(VECS[i].a, VECS[i].b, VECS[i].z, VECS[i].mode, 1'b0, 1'b0);
            check("R1..R9 table", res, VECS[i].exp);
        end

        // R6: condition encoding, computed before the max swap
        apply(64'd5, 64'd9, 1'b0, 3'b001, 1'b1, 1'b0);
        check("R6 less in max mode", {60'd0, cond}, 64'b1000);
        apply(64'd9, 64'd5, 1'b0, 3'b000, 1'b1, 1'b1);
        check("R6 greater with so", {60'd0, cond}, 64'b0101);
        apply(64'd4, 64'd4, 1'b0, 3'b001, 1'b1, 1'b0);
        check("R6 equal", {60'd0, cond}, 64'b0010);
        check("R8 tie max gives B", res, 64'd4);

        // R7: write enable follows the record flag
        check("R7 we high", {63'd0, cond_we}, 64'd1);
        apply(64'd1, 64'd2, 1'b0, 3'b000, 1'b0, 1'b1);
        check("R7 we low", {63'd0, cond_we}, 64'd0);

        // R4: upper halves ignored in word mode (A upper larger, low smaller)
        apply(64'hFFFF_0000_0000_0001, 64'h0000_0000_0000_0002, 1'b0, 3'b101, 1'b0, 1'b0);
        check("R4 word max ignores upper", res, 64'h0000_0000_0000_0002);

        // R1: zero substitution under max
        apply(64'hAAAA, 64'd0, 1'b1, 3'b001, 1'b0, 1'b0);
        check("R1 zero A tie gives B", res, 64'd0);

        // Reference sweeps across all modes
        sweep(64'd5, 64'd9, 1'b0);
        sweep(64'h8000_0000_0000_0000, 64'h7FFF_FFFF_FFFF_FFFF, 1'b0);
        sweep(64'h0000_0000_8000_0000, 64'h0000_0000_7FFF_FFFF, 1'b0);
        sweep(64'hDEAD_0000_0000_0010, 64'h0000_BEEF_0000_0010, 1'b0);
        sweep(64'h1111_2222_3333_4444, 64'h1111_2222_3333_4444, 1'b0);
        sweep(64'hFFFF_FFFF_FFFF_FFFF, 64'h0000_0000_0000_0001, 1'b1);

        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule